// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 16-bit virtual address into an 18-bit or 22-bit physical address. The top three virtual bits pick one of eight pages. The page's base register, scaled by 64, is added to the 13-bit offset. Each processor mode (kernel, supervisor, user) has its own set of page registers, split into instruction and data halves. A per-mode enable decides whether data references use the data half. Each page also has a descriptor word. The descriptor holds an access-control code, a length in 64-byte blocks, a growth direction and two sticky flags: an "accessed/aborted" flag and a "written" flag.

The translation path is purely combinational. The physical address and the abort kind are valid in the same cycle as the request. A translation marked valid updates the descriptor flags at the next clock edge. A register port reads and writes the base and descriptor words by word or by byte. The block also drives the base address of the I/O page for the current mapping mode. Status capture and trap dispatch belong to the surrounding processor logic.

Top module: `vpage_xlate`

## Requirements
- R1: When translation is active, the physical address is the selected page base register times 64 plus `xl_vaddr[12:0]`, where `xl_vaddr[15:13]` selects the page and `xl_mode` selects the register set (kernel 0, supervisor 1, user 3).
- R2: With `map22` low, the sum is truncated to its low 18 bits. With `map22` high, all 22 bits are kept.
- R3: Translation is active when `mmu_en` is high, or when `maint_wr` and `xl_write` are both high. When it is inactive, `phys_addr` equals the zero-extended virtual address and `abort_kind` is 0.
- R4: A data reference (`xl_data`=1) uses the data-space registers only if the mode's bit in `dspace_en` is set: kernel bit 2, supervisor bit 1, user bit 0. Otherwise it uses the instruction-space registers. Mode 2 never uses data space.
- R5: The access-control code sits in descriptor bits 2:0. Codes 0, 3, 4 and 7 abort as non-resident (`abort_kind`=1). Codes 1 and 2 are read-only, so a write to them aborts with `abort_kind`=2. Codes 5 and 6 allow reads and writes. This check takes priority over R7 and R6.
- R6: The length check compares `xl_vaddr[12:6]` with descriptor bits 14:8. If descriptor bit 3 is 0 (upward growth), a block above the length aborts. If bit 3 is 1 (downward growth), a block below the length aborts. A length abort gives `abort_kind`=3.
- R7: A mapped address at or above `MEM_PAGES`×8192 but below the I/O page base aborts as non-resident (`abort_kind`=1). This check takes priority over R6.
- R8: A valid, active write that aborts sets descriptor bit 7 at the next clock edge. A valid, active, non-aborted word write (`xl_byte`=0) sets descriptor bit 6. Reads and byte writes leave bit 6 alone.
- R9: Register port decode works as follows. `reg_addr[4]` selects data space, `reg_addr[3:1]` selects the page, `reg_mode` selects the mode and `reg_par` picks the base register (1) or the descriptor (0). In byte mode, `reg_addr[0]` picks the lane: the write uses `reg_wdata[7:0]`, and the read returns the lane in bits 7:0 with the upper bits zero.
- R10: Writing a descriptor stores the value with bits 15, 7, 6, 5 and 4 cleared. Writing a base register clears bits 7 and 6 of the matching descriptor. A port write wins over a flag update to the same entry in the same cycle.
- R11: `io_base` is octal 0160000 when `mmu_en` is low. It is octal 0760000 when `mmu_en` is high and `map22` is low, and octal 017760000 when both are high.
- R12: Synchronous reset clears every base register and descriptor to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_valid | input | 1 | Request is real; enables flag updates |
| xl_vaddr | input | 16 | Virtual address |
| xl_mode | input | 2 | Processor mode of the request |
| xl_data | input | 1 | Data-space reference |
| xl_write | input | 1 | Write request |
| xl_byte | input | 1 | Byte-sized write |
| mmu_en | input | 1 | Translation enable |
| maint_wr | input | 1 | Translate writes even while disabled |
| map22 | input | 1 | Keep 22-bit physical addresses |
| dspace_en | input | 3 | Per-mode data-space enables (kernel, supervisor, user) |
| reg_wr | input | 1 | Register port write strobe |
| reg_mode | input | 2 | Register port mode select |
| reg_par | input | 1 | 1 selects the base register, 0 the descriptor |
| reg_addr | input | 5 | Space, page and byte-lane select |
| reg_byte | input | 1 | Byte-wide port access |
| reg_wdata | input | 16 | Port write data |
| reg_rdata | output | 16 | Port read data (combinational) |
| phys_addr | output | 22 | Physical address |
| abort_kind | output | 2 | 0 none, 1 non-resident, 2 read-only, 3 length |
| io_base | output | 22 | Base of the I/O page |

## Verification
The flag assertions assume the register port and the translation request may address the same entry in the same cycle, and only claim the port-write outcome in that case. The abort assertions assume `xl_write` and the translation-enable inputs are held across the cycle being checked. The stimulus changes inputs only at the falling edge, so every request stays stable from one rising edge to the next. It pulses `xl_valid` for exactly one cycle around each flag test. The translation sweeps keep every base register below octal 040000, so memory-size aborts appear only where a test sets them up on purpose.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
    localparam int VA_W   = 16;
    localparam int PA_W   = 22;
    localparam int OFF_W  = 13;
    localparam int PG_W   = VA_W - OFF_W;
    localparam int MODE_W = 2;
    localparam int LEN_W  = 7;
    localparam int AC_W   = 3;
    localparam int IDX_W  = MODE_W + 1 + PG_W;
    localparam int NENT   = 1 << IDX_W;
    localparam int BLK_LO = 6;

    // descriptor flag positions and clearing masks
    localparam int            PD_WRITTEN  = 6;
    localparam int            PD_ACCESSED = 7;
    localparam logic [15:0]   PD_WR_CLEAR = 16'h80F0;
    localparam logic [15:0]   PB_WR_CLEAR = 16'h00C0;

    typedef enum logic [1:0] {
        AB_NONE   = 2'd0,
        AB_NONRES = 2'd1,
        AB_RDONLY = 2'd2,
        AB_LENGTH = 2'd3
    } abort_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             dir;
        logic [AC_W-1:0]  ac;
    } desc_t;

    function automatic logic ac_nonres(input logic [AC_W-1:0] ac);
        return (ac[1:0] == 2'd0) || (ac[1:0] == 2'd3);
    endfunction

    function automatic logic ac_writable(input logic [AC_W-1:0] ac);
        return (ac == 3'd5) || (ac == 3'd6);
    endfunction

    function automatic logic use_dspace(input logic [MODE_W-1:0] mode,
                                        input logic [2:0] den);
        case (mode)
            2'd0:    return den[2];
            2'd1:    return den[1];
            2'd3:    return den[0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [PA_W-1:0] io_base_of(input logic en, input logic wide);
        if (!en)  return 22'o0160000;
        if (wide) return 22'o17760000;
        return 22'o0760000;
    endfunction

    function automatic logic [15:0] lane_merge(input logic [15:0] old,
                                               input logic [15:0] wd,
                                               input logic byte_m,
                                               input logic lane);
        if (!byte_m) return wd;
        if (lane)    return {wd[7:0], old[7:0]};
        return {old[15:8], wd[7:0]};
    endfunction
endpackage

// File: rtl/vpx_regfile.sv
module vpx_regfile
    import vpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    // register port
    input  logic              reg_wr,
    input  logic [MODE_W-1:0] reg_mode,
    input  logic              reg_par,
    input  logic [4:0]        reg_addr,
    input  logic              reg_byte,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    // lookup and flag update
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [15:0]       lk_base,
    output desc_t             lk_desc,
    input  logic              fl_valid,
    input  logic              fl_set_w,
    input  logic              fl_set_a
);
    logic [15:0] base_q [NENT];
    logic [15:0] desc_q [NENT];
    logic [IDX_W-1:0] pidx;
    logic [15:0] psel;

    assign pidx = {reg_mode, reg_addr[4], reg_addr[3:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) begin
                base_q[i] <= '0;
                desc_q[i] <= '0;
            end
        end else begin
            if (fl_valid) begin
                if (fl_set_w) desc_q[lk_idx][PD_WRITTEN]  <= 1'b1;
                if (fl_set_a) desc_q[lk_idx][PD_ACCESSED] <= 1'b1;
            end
            // port write comes last so it wins on the same entry
            if (reg_wr) begin
                if (reg_par) begin
                    base_q[pidx] <= lane_merge(base_q[pidx], reg_wdata, reg_byte, reg_addr[0]);
                    desc_q[pidx] <= desc_q[pidx] & ~PB_WR_CLEAR;
                end else begin
                    desc_q[pidx] <= lane_merge(desc_q[pidx], reg_wdata, reg_byte, reg_addr[0])
                                    & ~PD_WR_CLEAR;
                end
            end
        end
    end

    assign psel = reg_par ? base_q[pidx] : desc_q[pidx];

    always_comb begin
        if (!reg_byte)        reg_rdata = psel;
        else if (reg_addr[0]) reg_rdata = {8'h00, psel[15:8]};
        else                  reg_rdata = {8'h00, psel[7:0]};
    end

    assign lk_base = base_q[lk_idx];
    assign lk_desc = '{len: desc_q[lk_idx][14:8], dir: desc_q[lk_idx][3], ac: desc_q[lk_idx][2:0]};

    // R10: descriptor write leaves the cleared bits at zero
    a_r10_desc_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_par) |=> ((desc_q[$past(pidx)] & PD_WR_CLEAR) == 16'h0000));

    // R10: base write clears the two flags of its descriptor
    a_r10_base_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_par) |=> (desc_q[$past(pidx)][7:6] == 2'b00));

    // R8: an aborted write leaves the accessed flag set
    a_r8_abort_flag: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && fl_set_a && !reg_wr) |=> desc_q[$past(lk_idx)][PD_ACCESSED]);

    // R8: a clean word write leaves the written flag set
    a_r8_written_flag: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && fl_set_w && !reg_wr) |=> desc_q[$past(lk_idx)][PD_WRITTEN]);
endmodule

// File: rtl/vpx_check.sv
module vpx_check
    import vpx_pkg::*;
#(
    parameter int MEM_PAGES = 32
) (
    input  logic              active,
    input  logic              is_write,
    input  desc_t             desc,
    input  logic [LEN_W-1:0]  blk,
    input  logic [PA_W-1:0]   phys,
    input  logic [PA_W-1:0]   io_lo,
    output abort_e            kind
);
    localparam longint unsigned MEM_LIMIT = longint'(MEM_PAGES) * 64'd8192;

    logic beyond_mem;
    logic len_bad;

    assign beyond_mem = (64'(phys) >= MEM_LIMIT) && (phys < io_lo);
    assign len_bad    = desc.dir ? (blk < desc.len) : (blk > desc.len);

    always_comb begin
        kind = AB_NONE;
        if (active) begin
            if (ac_nonres(desc.ac))                      kind = AB_NONRES;
            else if (is_write && !ac_writable(desc.ac))  kind = AB_RDONLY;
            else if (beyond_mem)                         kind = AB_NONRES;
            else if (len_bad)                            kind = AB_LENGTH;
        end
    end
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
    import vpx_pkg::*;
#(
    parameter int MEM_PAGES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xl_valid,
    input  logic [15:0] xl_vaddr,
    input  logic [1:0]  xl_mode,
    input  logic        xl_data,
    input  logic        xl_write,
    input  logic        xl_byte,
    input  logic        mmu_en,
    input  logic        maint_wr,
    input  logic        map22,
    input  logic [2:0]  dspace_en,
    input  logic        reg_wr,
    input  logic [1:0]  reg_mode,
    input  logic        reg_par,
    input  logic [4:0]  reg_addr,
    input  logic        reg_byte,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [21:0] phys_addr,
    output logic [1:0]  abort_kind,
    output logic [21:0] io_base
);
    logic              active;
    logic              dsel;
    logic [IDX_W-1:0]  lidx;
    logic [15:0]       base;
    desc_t             desc;
    logic [PA_W-1:0]   sum;
    logic [PA_W-1:0]   mapped;
    abort_e            kind;

    assign active = mmu_en || (xl_write && maint_wr);
    assign dsel   = xl_data && use_dspace(xl_mode, dspace_en);
    assign lidx   = {xl_mode, dsel, xl_vaddr[VA_W-1:OFF_W]};

    vpx_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_mode  (reg_mode),
        .reg_par   (reg_par),
        .reg_addr  (reg_addr),
        .reg_byte  (reg_byte),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_idx    (lidx),
        .lk_base   (base),
        .lk_desc   (desc),
        .fl_valid  (xl_valid && active),
        .fl_set_w  (xl_write && !xl_byte && (kind == AB_NONE)),
        .fl_set_a  (xl_write && (kind != AB_NONE))
    );

    assign sum    = {base, 6'b000000} + {{(PA_W-OFF_W){1'b0}}, xl_vaddr[OFF_W-1:0]};
    assign mapped = map22 ? sum : {4'b0000, sum[17:0]};
    assign io_base = io_base_of(mmu_en, map22);

    vpx_check #(.MEM_PAGES(MEM_PAGES)) u_chk (
        .active   (active),
        .is_write (xl_write),
        .desc     (desc),
        .blk      (xl_vaddr[OFF_W-1:BLK_LO]),
        .phys     (mapped),
        .io_lo    (io_base),
        .kind     (kind)
    );

    assign phys_addr  = active ? mapped : {{(PA_W-VA_W){1'b0}}, xl_vaddr};
    assign abort_kind = kind;

    // R3: untranslated requests pass the address through and never abort
    a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
        (!mmu_en && !(maint_wr && xl_write)) |-> (phys_addr[15:0] == xl_vaddr && abort_kind == 2'd0));

    // R5: a read-only abort only ever comes from a write
    a_r5_rdonly_needs_write: assert property (@(posedge clk) disable iff (rst)
        (abort_kind == 2'd2) |-> xl_write);

    // R2: narrow mapping keeps the top four address bits clear
    a_r2_narrow_top_clear: assert property (@(posedge clk) disable iff (rst)
        (mmu_en && !map22) |-> (phys_addr[21:18] == 4'h0));
endmodule

// File: tb/test_vpage_xlate.sv
module test_vpage_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic        xl_valid, xl_data, xl_write, xl_byte;
    logic [15:0] xl_vaddr;
    logic [1:0]  xl_mode;
    logic        mmu_en, maint_wr, map22;
    logic [2:0]  dspace_en;
    logic        reg_wr, reg_par, reg_byte;
    logic [1:0]  reg_mode;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [21:0] phys_addr, io_base;
    logic [1:0]  abort_kind;

    int checks = 0;
    int errors = 0;
    logic [15:0] par_m [64];
    logic [15:0] pdr_m [64];

    always #4 clk = ~clk;

    vpage_xlate #(.MEM_PAGES(256)) i_vpage_xlate (
        .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_vaddr(xl_vaddr),
        .xl_mode(xl_mode), .xl_data(xl_data), .xl_write(xl_write), .xl_byte(xl_byte),
        .mmu_en(mmu_en), .maint_wr(maint_wr), .map22(map22), .dspace_en(dspace_en),
        .reg_wr(reg_wr), .reg_mode(reg_mode), .reg_par(reg_par), .reg_addr(reg_addr),
        .reg_byte(reg_byte), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .phys_addr(phys_addr), .abort_kind(abort_kind), .io_base(io_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int bidx(input int m, input int d, input int p);
        return m * 16 + d * 8 + p;
    endfunction

    task automatic rwrite(input int m, input int d, input int p, input bit par,
                          input bit bmode, input bit lane, input logic [15:0] val);
        int k;
        @(negedge clk);
        reg_wr = 1'b1; reg_mode = 2'(m); reg_par = par; reg_byte = bmode;
        reg_addr = {1'(d), 3'(p), lane}; reg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        k = bidx(m, d, p);
        if (par) begin
            if (!bmode) par_m[k] = val;
            else if (lane) par_m[k][15:8] = val[7:0];
            else par_m[k][7:0] = val[7:0];
            pdr_m[k] = pdr_m[k] & ~16'h00C0;
        end else begin
            if (!bmode) pdr_m[k] = val;
            else if (lane) pdr_m[k][15:8] = val[7:0];
            else pdr_m[k][7:0] = val[7:0];
            pdr_m[k] = pdr_m[k] & ~16'h80F0;
        end
    endtask

    task automatic rread(input int m, input int d, input int p, input bit par,
                         input bit bmode, input bit lane, output logic [15:0] v);
        reg_wr = 1'b0; reg_mode = 2'(m); reg_par = par; reg_byte = bmode;
        reg_addr = {1'(d), 3'(p), lane};
        #1 v = reg_rdata;
    endtask

    task automatic xl_set(input logic [15:0] va, input int m, input bit d, input bit wr, input bit bt);
        xl_vaddr = va; xl_mode = 2'(m); xl_data = d; xl_write = wr; xl_byte = bt;
        #1;
    endtask

    task automatic xl_pulse(input logic [15:0] va, input int m, input bit d, input bit wr, input bit bt);
        @(negedge clk);
        xl_vaddr = va; xl_mode = 2'(m); xl_data = d; xl_write = wr; xl_byte = bt;
        xl_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xl_valid = 1'b0;
    endtask

    function automatic logic [21:0] exp_map(input logic [15:0] par, input logic [15:0] va, input bit w22);
        logic [31:0] s;
        s = {10'd0, par, 6'd0} + {19'd0, va[12:0]};
        return w22 ? s[21:0] : {4'd0, s[17:0]};
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] offs [4];
        logic [2:0]  dens [3];
        int          modes [3];
        offs[0] = 16'h0000; offs[1] = 16'h0040; offs[2] = 16'h1FFF; offs[3] = 16'h0ABC;
        dens[0] = 3'b000; dens[1] = 3'b111; dens[2] = 3'b100;
        modes[0] = 0; modes[1] = 1; modes[2] = 3;

        rst = 1'b1; xl_valid = 0; xl_vaddr = 0; xl_mode = 0; xl_data = 0; xl_write = 0;
        xl_byte = 0; mmu_en = 0; maint_wr = 0; map22 = 0; dspace_en = 0;
        reg_wr = 0; reg_mode = 0; reg_par = 0; reg_addr = 0; reg_byte = 0; reg_wdata = 0;
        for (int i = 0; i < 64; i++) begin par_m[i] = 0; pdr_m[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: all registers zero after reset
        for (int k = 0; k < 64; k++) begin
            rread(k / 16, (k / 8) % 2, k % 8, 1'b1, 1'b0, 1'b0, v); check("R12 base", v, 0);
            rread(k / 16, (k / 8) % 2, k % 8, 1'b0, 1'b0, 1'b0, v); check("R12 desc", v, 0);
        end

        // R9 R10: fill every entry, descriptors with cleared bits set on odd entries
        for (int k = 0; k < 64; k++) begin
            rwrite(k / 16, (k / 8) % 2, k % 8, 1'b1, 1'b0, 1'b0, 16'(((k + 1) * 16'h0135) & 16'h3FFF));
            rwrite(k / 16, (k / 8) % 2, k % 8, 1'b0, 1'b0, 1'b0, (k % 2) ? 16'hFFF6 : 16'h7F06);
        end
        for (int k = 0; k < 64; k++) begin
            rread(k / 16, (k / 8) % 2, k % 8, 1'b1, 1'b0, 1'b0, v); check("R9 base readback", v, par_m[k]);
            rread(k / 16, (k / 8) % 2, k % 8, 1'b0, 1'b0, 1'b0, v); check("R10 desc clear", v, 16'h7F06);
        end

        // R9: byte lanes
        rwrite(0, 0, 5, 1'b1, 1'b1, 1'b1, 16'h002A);
        rread(0, 0, 5, 1'b1, 1'b1, 1'b1, v); check("R9 byte hi", v, 16'h002A);
        rread(0, 0, 5, 1'b1, 1'b1, 1'b0, v); check("R9 byte lo", v, {8'h00, par_m[bidx(0,0,5)][7:0]});
        rread(0, 0, 5, 1'b1, 1'b0, 1'b0, v); check("R9 byte word", v, par_m[bidx(0,0,5)]);
        rwrite(1, 1, 3, 1'b0, 1'b1, 1'b0, 16'h00FD);
        rread(1, 1, 3, 1'b0, 1'b0, 1'b0, v); check("R10 byte desc clear", v, 16'h7F0D);
        rwrite(1, 1, 3, 1'b0, 1'b0, 1'b0, 16'h7F06);

        // R1 R2 R4: translation sweep
        mmu_en = 1'b1;
        for (int w = 0; w < 2; w++)
            for (int e = 0; e < 3; e++)
                for (int mi = 0; mi < 3; mi++)
                    for (int d = 0; d < 2; d++)
                        for (int p = 0; p < 8; p++)
                            for (int o = 0; o < 4; o++) begin
                                int m, ds;
                                logic [15:0] va;
                                m = modes[mi];
                                map22 = 1'(w); dspace_en = dens[e];
                                ds = (d == 1) && ((m == 0 && dens[e][2]) || (m == 1 && dens[e][1]) || (m == 3 && dens[e][0])) ? 1 : 0;
                                va = {3'(p), offs[o][12:0]};
                                xl_set(va, m, 1'(d), 1'b0, 1'b0);
                                check("R1 R2 R4 map", {8'd0, abort_kind, phys_addr},
                                      {8'd0, 2'd0, exp_map(par_m[bidx(m, ds, p)], va, w == 1)});
                            end

        // R4: mode 2 data never uses data space
        dspace_en = 3'b111; map22 = 1'b1;
        xl_set(16'h6010, 2, 1'b1, 1'b0, 1'b0);
        check("R4 mode2 ispace", phys_addr, exp_map(par_m[bidx(2,0,3)], 16'h6010, 1'b1));

        // R11: I/O page base
        mmu_en = 0; #1 check("R11 off", io_base, 22'o0160000);
        mmu_en = 1; map22 = 0; #1 check("R11 18bit", io_base, 22'o0760000);
        map22 = 1; #1 check("R11 22bit", io_base, 22'o17760000);

        // R3: disabled passthrough, maintenance writes translate
        mmu_en = 0; maint_wr = 0;
        xl_set(16'hBEEF, 3, 1'b0, 1'b1, 1'b0); check("R3 pass write", {abort_kind, phys_addr}, {2'd0, 22'h00BEEF});
        xl_set(16'h1234, 0, 1'b1, 1'b0, 1'b0); check("R3 pass read", {abort_kind, phys_addr}, {2'd0, 22'h001234});
        maint_wr = 1; dspace_en = 0;
        xl_set(16'hBEEF, 3, 1'b0, 1'b1, 1'b0);
        check("R3 maint write", phys_addr, exp_map(par_m[bidx(3,0,5)], 16'hBEEF, 1'b1));
        xl_set(16'h1234, 0, 1'b1, 1'b0, 1'b0); check("R3 maint read pass", phys_addr, 22'h001234);
        maint_wr = 0; mmu_en = 1; map22 = 1; dspace_en = 0;

        // R5: access codes on user I page 2
        for (int ac = 0; ac < 8; ac++) begin
            int er, ew;
            rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h7F00 | 16'(ac));
            er = (ac == 0 || ac == 3 || ac == 4 || ac == 7) ? 1 : 0;
            ew = er ? 1 : ((ac == 1 || ac == 2) ? 2 : 0);
            xl_set(16'h4100, 3, 1'b0, 1'b0, 1'b0); check("R5 read", abort_kind, er);
            xl_set(16'h4100, 3, 1'b0, 1'b1, 1'b0); check("R5 write", abort_kind, ew);
        end

        // R6: length in both directions
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h0506);
        xl_set(16'h4000 | (16'd5 << 6), 3, 1'b0, 1'b0, 1'b0); check("R6 up at len", abort_kind, 0);
        xl_set(16'h4000 | (16'd6 << 6), 3, 1'b0, 1'b0, 1'b0); check("R6 up over", abort_kind, 3);
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h050E);
        xl_set(16'h4000 | (16'd5 << 6), 3, 1'b0, 1'b0, 1'b0); check("R6 down at len", abort_kind, 0);
        xl_set(16'h4000 | (16'd4 << 6), 3, 1'b0, 1'b0, 1'b0); check("R6 down under", abort_kind, 3);
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h0500);
        xl_set(16'h4000 | (16'd9 << 6), 3, 1'b0, 1'b0, 1'b0); check("R5 R6 priority", abort_kind, 1);

        // R7: installed memory limit (2 MiB) and I/O page exemption
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h0506);
        rwrite(3, 0, 2, 1'b1, 1'b0, 1'b0, 16'h7FFF);
        xl_set(16'h403F, 3, 1'b0, 1'b0, 1'b0); check("R7 below limit", {abort_kind, phys_addr}, {2'd0, 22'h1FFFFF});
        xl_set(16'h4040, 3, 1'b0, 1'b0, 1'b0); check("R7 beyond limit", abort_kind, 1);
        xl_set(16'h4400, 3, 1'b0, 1'b0, 1'b0); check("R7 beats length", abort_kind, 1);
        map22 = 0;
        xl_set(16'h4040, 3, 1'b0, 1'b0, 1'b0); check("R7 R2 wrap", {abort_kind, phys_addr}, {2'd0, 22'h000000});
        map22 = 1;
        rwrite(3, 0, 2, 1'b1, 1'b0, 1'b0, 16'hFF80);
        xl_set(16'h4000, 3, 1'b0, 1'b0, 1'b0); check("R7 io page ok", {abort_kind, phys_addr}, {2'd0, 22'o17760000});

        // R8: flag updates
        rwrite(3, 0, 2, 1'b1, 1'b0, 1'b0, 16'h0100);
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h7F06);
        xl_pulse(16'h4010, 3, 1'b0, 1'b0, 1'b0);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 read no flag", v, 16'h7F06);
        xl_pulse(16'h4010, 3, 1'b0, 1'b1, 1'b1);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 byte write no flag", v, 16'h7F06);
        xl_set(16'h4010, 3, 1'b0, 1'b1, 1'b0);
        check("R8 no pulse no flag", 32'(abort_kind), 0);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 valid low no flag", v, 16'h7F06);
        xl_pulse(16'h4010, 3, 1'b0, 1'b1, 1'b0);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 word write sets W", v, 16'h7F46);
        rwrite(3, 0, 2, 1'b1, 1'b0, 1'b0, 16'h0100);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R10 base write clears flags", v, 16'h7F06);
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h7F02);
        xl_pulse(16'h4010, 3, 1'b0, 1'b1, 1'b0);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 write abort sets A", v, 16'h7F82);
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h7F00);
        xl_pulse(16'h4010, 3, 1'b0, 1'b0, 1'b0);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 read abort no A", v, 16'h7F00);
        rwrite(3, 0, 2, 1'b0, 1'b0, 1'b0, 16'h7F06);
        mmu_en = 0;
        xl_pulse(16'h4010, 3, 1'b0, 1'b1, 1'b0);
        rread(3, 0, 2, 1'b0, 1'b0, 1'b0, v); check("R8 inactive no W", v, 16'h7F06);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule